// File: doc/BRIEF.md
# Infrared Interaction Pulse Sequencer

This block decides what a fast infrared transmitter puts on its data pin between frames. When the transmitter is switched on, and again after every frame ends, it drives a timed interaction pulse. The pin goes high for 1.625 µs and then low for 7.375 µs, 9.0 µs in all. This pulse looks like a start bit to slow infrared stations and keeps them quiet. After the pulse the block repeats a preamble chip pattern on the pin. It does this until the transmit FIFO reports data, and then it hands the pin to the frame serializer at the end of a whole pattern group.

Turning the transmitter off stops the output in the same cycle, whatever the block was doing. In that cycle it pulses clear strobes to the serial shifter and the transmit FIFO, and hands the pin back to the general-purpose I/O logic. A watchdog counts the time since the last frame completed and raises a flag if 500 ms pass without one. The pulse lengths and the watchdog limit are derived from a clock-frequency parameter. The preamble is a parameterised bit pattern.

Top module: `irda_sip_seq`

## Requirements
- R1: While the transmitter enable is low, tx_pin is 0, gpio_own is 1, and ser_start, ser_own and wdog_flag are 0. This also holds out of reset.
- R2: In the first clock cycle that finds tx_en high after a disabled cycle, the state moves to the pulse. tx_pin is then 1 for HI_CYC cycles and 0 for LO_CYC cycles, with HI_CYC = 1.625 µs and LO_CYC = 7.375 µs at CLK_HZ (78 and 354 at 48 MHz, 13 and 59 at 8 MHz).
- R3: After the pulse, tx_pin repeats PRE_PAT one bit per cycle, most significant bit first, for as long as data_avail is low.
- R4: ser_start is high for exactly one cycle, namely the cycle that outputs the last (least significant) pattern bit while data_avail is high. From the next cycle, ser_own is 1 and tx_pin follows ser_tx.
- R5: A frame_end strobe while the serializer owns the pin starts a new full interaction pulse in the next cycle.
- R6: data_avail raised during the pulse does not shorten it. The first ser_start comes HI_CYC+LO_CYC+PRE_BITS cycles after the pulse begins.
- R7: When tx_en goes low, tx_pin is 0 and gpio_own is 1 in the same cycle. shifter_clr and fifo_clr are both high for that one cycle only.
- R8: wdog_flag goes high once WDOG_US microseconds' worth of cycles have passed since enable or since the last completed frame. A completed frame or a disable clears it.
- R9: frame_end outside a frame (disabled, pulse, preamble) has no effect on the pin or ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| frame_end | input | 1 | End-of-frame strobe from the serializer |
| data_avail | input | 1 | Transmit FIFO holds data |
| ser_tx | input | 1 | Serializer's pin value during a frame |
| tx_pin | output | 1 | Transmit data pin |
| ser_start | output | 1 | One-cycle strobe telling the serializer to begin a frame |
| ser_own | output | 1 | Serializer currently drives the pin |
| gpio_own | output | 1 | Pin handed to general-purpose I/O |
| shifter_clr | output | 1 | Clear strobe for the serial shifter |
| fifo_clr | output | 1 | Clear strobe for the transmit FIFO |
| wdog_flag | output | 1 | No frame completed within the watchdog window |

## Verification
The embedded assertions watch properties that hold on every cycle:
- the pulse counter stays in range;
- an enable and a frame end each lead straight into a high pulse cycle;
- a start strobe is followed by serializer ownership;
- the clear strobes last a single cycle;
- the watchdog flag stays raised until a frame completes or the transmitter is disabled.

Other behaviours need the bench's scenarios and its reference model:
- the exact pulse lengths and the preamble bit order;
- that a handoff happens only at a group boundary;
- that data arriving mid-pulse does not shorten the pulse;
- that stray frame_end strobes have no effect;
- the watchdog timing.

// File: rtl/irda_sip_seq.sv
module irda_sip_seq #(
  parameter int unsigned CLK_HZ   = 48_000_000,
  parameter int unsigned HI_NS    = 1625,
  parameter int unsigned LO_NS    = 7375,
  parameter int unsigned WDOG_US  = 500_000,
  parameter int unsigned PRE_BITS = 8,
  parameter logic [PRE_BITS-1:0] PRE_PAT = 8'b1100_1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic frame_end,
  input  logic data_avail,
  input  logic ser_tx,
  output logic tx_pin,
  output logic ser_start,
  output logic ser_own,
  output logic gpio_own,
  output logic shifter_clr,
  output logic fifo_clr,
  output logic wdog_flag
);

  localparam int unsigned HI_CYC   = (CLK_HZ / 1000) * HI_NS / 1_000_000;
  localparam int unsigned LO_CYC   = (CLK_HZ / 1000) * LO_NS / 1_000_000;
  localparam int unsigned MAX_CYC  = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int unsigned CW       = $clog2(MAX_CYC + 1);
  localparam int unsigned PW       = (PRE_BITS > 1) ? $clog2(PRE_BITS) : 1;
  localparam int unsigned WDOG_CYC = (CLK_HZ / 1_000_000) * WDOG_US;
  localparam int unsigned WW       = $clog2(WDOG_CYC + 1);

  localparam logic [CW-1:0] HI_LAST = CW'(HI_CYC - 1);
  localparam logic [CW-1:0] LO_LAST = CW'(LO_CYC - 1);
  localparam logic [PW-1:0] P_LAST  = PW'(PRE_BITS - 1);
  localparam logic [WW-1:0] WD_MAX  = WW'(WDOG_CYC);

  typedef enum logic [2:0] {S_OFF, S_HI, S_LO, S_PRE, S_FRM} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pidx;
  logic [WW-1:0] wd;
  logic          pin_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      cnt   <= '0;
      pidx  <= '0;
      wd    <= '0;
    end else if (!tx_en) begin
      state <= S_OFF;
      cnt   <= '0;
      pidx  <= '0;
      wd    <= '0;
    end else begin
      if (state == S_OFF || (state == S_FRM && frame_end)) wd <= '0;
      else if (wd != WD_MAX) wd <= wd + 1'b1;
      case (state)
        S_OFF: begin
          state <= S_HI;
          cnt   <= '0;
        end
        S_HI: begin
          if (cnt == HI_LAST) begin
            state <= S_LO;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_LO: begin
          if (cnt == LO_LAST) begin
            state <= S_PRE;
            cnt   <= '0;
            pidx  <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_PRE: begin
          if (pidx == P_LAST) begin
            pidx <= '0;
            if (data_avail) state <= S_FRM;
          end else pidx <= pidx + 1'b1;
        end
        S_FRM: begin
          if (frame_end) begin
            state <= S_HI;
            cnt   <= '0;
          end
        end
        default: state <= S_OFF;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_HI:    pin_int = 1'b1;
      S_PRE:   pin_int = PRE_PAT[P_LAST - pidx];
      S_FRM:   pin_int = ser_tx;
      default: pin_int = 1'b0;
    endcase
  end

  assign tx_pin      = tx_en & pin_int;
  assign ser_start   = tx_en & (state == S_PRE) & (pidx == P_LAST) & data_avail;
  assign ser_own     = tx_en & (state == S_FRM);
  assign gpio_own    = ~tx_en | (state == S_OFF);
  assign shifter_clr = ~tx_en & (state != S_OFF);
  assign fifo_clr    = ~tx_en & (state != S_OFF);
  assign wdog_flag   = (wd == WD_MAX);

  AST_HI_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HI) |-> (cnt <= HI_LAST)); // R2
  AST_ENABLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OFF && tx_en) |=> (tx_pin || !tx_en)); // R2
  AST_START_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start |=> (ser_own || !tx_en)); // R4
  AST_FRAME_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_own && frame_end) |=> (tx_pin || !tx_en)); // R5
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    shifter_clr |=> !fifo_clr); // R7
  AST_WDOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_flag && tx_en && !(ser_own && frame_end)) |=> wdog_flag); // R8

endmodule

// File: tb/irda_sip_seq_tb_top.sv
module irda_sip_seq_tb_top;
  localparam int HI  = 13;   // 1.625 us at 8 MHz
  localparam int LO  = 59;   // 7.375 us at 8 MHz
  localparam int WDC = 800;  // 100 us at 8 MHz
  localparam int PB  = 8;
  localparam logic [7:0] PAT = 8'b1100_1010;

  logic clk = 0, rst_n = 0;
  logic tx_en = 0, frame_end = 0, data_avail = 0, ser_tx = 0;
  logic tx_pin, ser_start, ser_own, gpio_own, shifter_clr, fifo_clr, wdog_flag;

  int n_cmp = 0, n_bad = 0;
  bit running = 0;

  always #5 clk = ~clk;

  irda_sip_seq #(.CLK_HZ(8_000_000), .WDOG_US(100)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .frame_end(frame_end),
    .data_avail(data_avail), .ser_tx(ser_tx), .tx_pin(tx_pin),
    .ser_start(ser_start), .ser_own(ser_own), .gpio_own(gpio_own),
    .shifter_clr(shifter_clr), .fifo_clr(fifo_clr), .wdog_flag(wdog_flag));

  // reference model: 0 off, 1 high, 2 low, 3 preamble, 4 frame
  int ph = 0, left = 0, bitn = 0, wdc = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !tx_en) begin
      ph = 0; wdc = 0; bitn = 0; left = 0;
    end else begin
      if (ph == 0 || (ph == 4 && frame_end)) wdc = 0;
      else if (wdc < WDC) wdc++;
      case (ph)
        0: begin ph = 1; left = HI; end
        1: begin left--; if (left == 0) begin ph = 2; left = LO; end end
        2: begin left--; if (left == 0) begin ph = 3; bitn = 0; end end
        3: begin
          if (bitn == PB - 1) begin bitn = 0; if (data_avail) ph = 4; end
          else bitn++;
        end
        default: if (frame_end) begin ph = 1; left = HI; end
      endcase
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      #2;
      begin
        logic e_pin;
        string pr;
        e_pin = tx_en && (ph == 1 || (ph == 3 && PAT[PB-1-bitn]) || (ph == 4 && ser_tx));
        pr = !tx_en ? "R7" : (ph == 0) ? "R1" : (ph <= 2) ? "R2" : (ph == 3) ? "R3" : "R4";
        chk(tx_pin, e_pin, pr, "tx_pin");
        chk(ser_start, tx_en && ph == 3 && bitn == PB - 1 && data_avail, "R4", "ser_start");
        chk(ser_own, tx_en && ph == 4, "R4", "ser_own");
        chk(gpio_own, !tx_en || ph == 0, "R7", "gpio_own");
        chk(shifter_clr, !tx_en && ph != 0, "R7", "shifter_clr");
        chk(fifo_clr, !tx_en && ph != 0, "R7", "fifo_clr");
        chk(wdog_flag, wdc == WDC, "R8", "wdog_flag");
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_end();
    @(negedge clk) frame_end = 1;
    @(negedge clk) frame_end = 0;
  endtask

  task automatic wait_start(output int n);
    n = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk); #2; n++;
      if (ser_start) break;
    end
  endtask

  task automatic send_frame(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk) ser_tx = i[0] ^ i[2];
    end
    ser_tx = 0;
  endtask

  initial begin
    int n;
    cyc(3);
    rst_n = 1;
    running = 1;
    cyc(5); #2;
    chk(tx_pin, 0, "R1", "reset tx_pin");
    chk(gpio_own, 1, "R1", "reset gpio_own");
    chk(wdog_flag, 0, "R1", "reset wdog_flag");

    // R9: stray frame_end while disabled
    pulse_end();
    @(negedge clk) tx_en = 1;
    cyc(100);
    // R9: stray frame_end during preamble
    pulse_end(); #2;
    chk(ser_own, 0, "R9", "ser_own after stray frame_end");
    cyc(20);
    @(negedge clk) data_avail = 1;
    wait_start(n);
    chk(ser_start, 1, "R4", "start seen");
    @(negedge clk) data_avail = 0;
    send_frame(20);
    pulse_end(); #2;
    chk(tx_pin, 1, "R5", "pulse after frame_end");

    // R6: data during pulse
    cyc(2);
    @(negedge clk) data_avail = 1;
    wait_start(n);
    n = n + 4;  // cycles of pulse already elapsed before the wait began
    chk(n == HI + LO + PB, 1, "R6", "first start delay");
    if (n != HI + LO + PB) $display("FAIL R6 delay actual %0d expected %0d", n, HI + LO + PB);
    send_frame(10);
    @(negedge clk) data_avail = 0;
    pulse_end();

    // R7: disable mid-pulse
    cyc(5);
    @(negedge clk) tx_en = 0; #2;
    chk(tx_pin, 0, "R7", "pin low on disable");
    chk(shifter_clr, 1, "R7", "shifter_clr on disable");
    chk(fifo_clr, 1, "R7", "fifo_clr on disable");
    cyc(1); #2;
    chk(fifo_clr, 0, "R7", "fifo_clr single cycle");

    // R8: watchdog
    @(negedge clk) tx_en = 1;
    cyc(850); #2;
    chk(wdog_flag, 1, "R8", "watchdog expired");
    @(negedge clk) data_avail = 1;
    wait_start(n);
    @(negedge clk) data_avail = 0;
    send_frame(8);
    pulse_end(); #2;
    chk(wdog_flag, 0, "R8", "watchdog cleared by frame");

    // R7: disable mid-frame with serializer high
    cyc(HI + LO + 3);
    @(negedge clk) data_avail = 1;
    wait_start(n);
    @(negedge clk) ser_tx = 1;
    @(negedge clk) tx_en = 0; #2;
    chk(tx_pin, 0, "R7", "pin low mid-frame disable");
    chk(gpio_own, 1, "R7", "gpio owns pin");
    cyc(10);
    finish_run();
  end

  task automatic finish_run();
    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog timeout: actual running expected finished");
    finish_run();
  end
endmodule